// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the 32-bit execution datapath of a small processor whose control comes from a separate sequencer. Every transfer between storage elements passes over one shared bus. In any cycle the sequencer chooses at most one bus source: the register file, the immediate generator, the ALU or the external memory's read data. It then raises load strobes on the latches that should capture the bus value. The latches are the instruction latch, the two ALU operand latches (A and B) and the memory address latch. A write strobe on the register file can also capture the bus value.

The register file has 32 general registers plus one extra entry that holds the program counter. Its index is chosen each cycle from one of these: the destination, first source or second source field of the instruction latch; the fixed link register; or the program counter slot. For example, a move of the program counter to the memory address latch is one cycle. In that cycle the sequencer selects the program-counter slot, enables the register-file drive and strobes the address latch.

The block sends the instruction opcode and an A-equals-B flag back to the sequencer. A slow external memory signals that it is busy. While busy is high, a cycle that takes memory data onto the bus captures nothing anywhere.

Top module: `sbus_datapath`

## Requirements
- R1: When en_mem is high, the bus carries mem_rdata, and it is presented on mem_wdata. Among en_reg, en_imm, en_alu and en_mem, at most one is high in any cycle.
- R2: When no drive enable is high, the bus reads zero.
- R3: On a clock edge, ld_ir, ld_a, ld_b and ld_ma each capture the current bus value into the instruction, A, B and address latches. mem_addr shows the address latch. opcode shows instruction bits [6:0].
- R4: reg_sel picks the register-file index. The codes are: 0 = instruction bits [11:7], 1 = bits [24:20], 2 = bits [19:15], 3 = register 1, 4 = the program-counter entry, and 5 to 7 = register 0.
- R5: Register 0 always drives zero, and a write to it has no effect.
- R6: With reg_wr high, the bus value is written into the selected register-file entry at the clock edge. This includes register 1 and the program-counter entry.
- R7: imm_sel 0 drives instruction bits [31:20], sign-extended.
- R8: imm_sel 1 drives the branch offset. It is {bits[31:25], bits[11:7]}, sign-extended and shifted left by one.
- R9: imm_sel 2 drives bits [31:12], sign-extended and shifted left by one. imm_sel 3 drives bits [31:12] followed by twelve zeros.
- R10: alu_op selects the ALU result from A and B. The codes are: 0 add, 1 A minus B, 2 AND, 3 OR, 4 XOR, 5 signed less-than (1 or 0), 6 pass B, 7 A plus 4.
- R11: a_eq_b is high exactly when A equals B.
- R12: While en_mem and mem_busy are both high, no latch and no register-file entry changes.
- R13: After reset, every latch and register reads zero, except the program-counter entry, which holds RESET_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register-file index select |
| imm_sel | input | 2 | Immediate format select |
| alu_op | input | 3 | ALU function select |
| en_reg | input | 1 | Register file drives the bus |
| en_imm | input | 1 | Immediate generator drives the bus |
| en_alu | input | 1 | ALU drives the bus |
| en_mem | input | 1 | Memory read data drives the bus |
| ld_ir | input | 1 | Capture bus into instruction latch |
| ld_a | input | 1 | Capture bus into A |
| ld_b | input | 1 | Capture bus into B |
| ld_ma | input | 1 | Capture bus into address latch |
| reg_wr | input | 1 | Write bus into selected register |
| mem_write | input | 1 | Sequencer requests a memory write |
| mem_rdata | input | 32 | Memory read data |
| mem_busy | input | 1 | Memory not ready |
| mem_addr | output | 32 | Memory address latch |
| mem_wdata | output | 32 | Bus value toward memory |
| mem_we | output | 1 | Memory write enable |
| mem_en | output | 1 | Memory access enable |
| bus_o | output | 32 | Current bus value |
| opcode | output | 7 | Instruction bits [6:0] |
| a_eq_b | output | 1 | A equals B |

## Verification
The hardest situation to reach is a busy memory cycle that also carries load and write strobes. Reaching it requires holding both enables and strobes together. The later register-file, ALU and address outputs must then show that nothing moved. The random stimulus raises busy in about a quarter of the cycles, independently of which source drives the bus. A directed sequence first zeroes B and then loads A under busy. It then reads A back through the ALU adder.

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int W = 32,
  parameter int NREG = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   reg_sel,
  input  logic [1:0]   imm_sel,
  input  logic [2:0]   alu_op,
  input  logic         en_reg,
  input  logic         en_imm,
  input  logic         en_alu,
  input  logic         en_mem,
  input  logic         ld_ir,
  input  logic         ld_a,
  input  logic         ld_b,
  input  logic         ld_ma,
  input  logic         reg_wr,
  input  logic         mem_write,
  input  logic [31:0]  mem_rdata,
  input  logic         mem_busy,
  output logic [31:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  output logic         mem_we,
  output logic         mem_en,
  output logic [31:0]  bus_o,
  output logic [6:0]   opcode,
  output logic         a_eq_b
);
  localparam int IW = $clog2(NREG + 1);
  localparam int PC_IDX = NREG;

  logic [W-1:0] rf [NREG+1];
  logic [W-1:0] ir, a_q, b_q, ma;
  logic [IW-1:0] idx;
  logic [W-1:0] rf_val, imm, alu, bus;
  logic cap_ok;

  always_comb begin
    case (reg_sel)
      3'd0: idx = IW'(ir[11:7]);
      3'd1: idx = IW'(ir[24:20]);
      3'd2: idx = IW'(ir[19:15]);
      3'd3: idx = IW'(1);
      3'd4: idx = IW'(PC_IDX);
      default: idx = '0;
    endcase
  end

  assign rf_val = (idx == '0) ? '0 : rf[idx];

  always_comb begin
    case (imm_sel)
      2'd0: imm = {{20{ir[31]}}, ir[31:20]};
      2'd1: imm = {{19{ir[31]}}, ir[31:25], ir[11:7], 1'b0};
      2'd2: imm = {{11{ir[31]}}, ir[31:12], 1'b0};
      default: imm = {ir[31:12], 12'b0};
    endcase
  end

  always_comb begin
    case (alu_op)
      3'd0: alu = a_q + b_q;
      3'd1: alu = a_q - b_q;
      3'd2: alu = a_q & b_q;
      3'd3: alu = a_q | b_q;
      3'd4: alu = a_q ^ b_q;
      3'd5: alu = {{(W-1){1'b0}}, $signed(a_q) < $signed(b_q)};
      3'd6: alu = b_q;
      default: alu = a_q + W'(4);
    endcase
  end

  assign bus = ({W{en_reg}} & rf_val) | ({W{en_imm}} & imm)
             | ({W{en_alu}} & alu)    | ({W{en_mem}} & mem_rdata);
  assign cap_ok = !(en_mem && mem_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= NREG; i++)
        rf[i] <= (i == PC_IDX) ? RESET_PC : '0;
      ir  <= '0;
      a_q <= '0;
      b_q <= '0;
      ma  <= '0;
    end else if (cap_ok) begin
      if (ld_ir) ir  <= bus;
      if (ld_a)  a_q <= bus;
      if (ld_b)  b_q <= bus;
      if (ld_ma) ma  <= bus;
      if (reg_wr && idx != '0) rf[idx] <= bus;
    end
  end

  assign mem_addr  = ma;
  assign mem_wdata = bus;
  assign mem_we    = mem_write;
  assign mem_en    = en_mem | mem_write;
  assign bus_o     = bus;
  assign opcode    = ir[6:0];
  assign a_eq_b    = (a_q == b_q);
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_reg,
  input logic        en_imm,
  input logic        en_alu,
  input logic        en_mem,
  input logic        ld_ma,
  input logic        mem_busy,
  input logic [31:0] mem_rdata,
  input logic [31:0] bus_o,
  input logic [31:0] mem_addr
);
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({en_reg, en_imm, en_alu, en_mem}) <= 1); // R1
  AST_MEM_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    en_mem |-> bus_o == mem_rdata); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_reg || en_imm || en_alu || en_mem) |-> bus_o == 32'd0); // R2
  AST_MA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ma && !(en_mem && mem_busy)) |=> mem_addr == $past(bus_o)); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ma && en_mem && mem_busy) |=> $stable(mem_addr)); // R12
endmodule

bind sbus_datapath sbus_datapath_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_reg(en_reg), .en_imm(en_imm),
  .en_alu(en_alu), .en_mem(en_mem), .ld_ma(ld_ma), .mem_busy(mem_busy),
  .mem_rdata(mem_rdata), .bus_o(bus_o), .mem_addr(mem_addr)
);

// File: tb/sbus_datapath_tb_top.sv
module sbus_datapath_tb_top;
  localparam logic [31:0] RPC = 32'h0000_1000;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [2:0] reg_sel = 0, alu_op = 0;
  logic [1:0] imm_sel = 0;
  logic en_reg = 0, en_imm = 0, en_alu = 0, en_mem = 0;
  logic ld_ir = 0, ld_a = 0, ld_b = 0, ld_ma = 0, reg_wr = 0, mem_write = 0, mem_busy = 0;
  logic [31:0] mem_rdata = 0;
  logic [31:0] mem_addr, mem_wdata, bus_o;
  logic mem_we, mem_en, a_eq_b;
  logic [6:0] opcode;

  sbus_datapath #(.RESET_PC(RPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .imm_sel(imm_sel), .alu_op(alu_op),
    .en_reg(en_reg), .en_imm(en_imm), .en_alu(en_alu), .en_mem(en_mem),
    .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma), .reg_wr(reg_wr),
    .mem_write(mem_write), .mem_rdata(mem_rdata), .mem_busy(mem_busy),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_en(mem_en),
    .bus_o(bus_o), .opcode(opcode), .a_eq_b(a_eq_b));

  logic [31:0] m_rf [33];
  logic [31:0] m_ir, m_a, m_b, m_ma;
  int n_chk = 0, n_bad = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int f_idx(logic [2:0] s, logic [31:0] ir);
    case (s)
      3'd0: return int'(ir[11:7]);
      3'd1: return int'(ir[24:20]);
      3'd2: return int'(ir[19:15]);
      3'd3: return 1;
      3'd4: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] f_imm(logic [1:0] s, logic [31:0] ir);
    case (s)
      2'd0: return 32'($signed(ir[31:20]));
      2'd1: return 32'($signed({ir[31:25], ir[11:7]})) << 1;
      2'd2: return 32'($signed(ir[31:12])) << 1;
      default: return {ir[31:12], 12'h000};
    endcase
  endfunction

  function automatic logic [31:0] f_alu(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'd6: return b;
      default: return a + 32'd4;
    endcase
  endfunction

  function automatic string src_tag();
    if (en_reg) return (f_idx(reg_sel, m_ir) == 0) ? "R5" : "R4";
    if (en_imm) return (imm_sel == 0) ? "R7" : (imm_sel == 1) ? "R8" : "R9";
    if (en_alu) return "R10";
    if (en_mem) return "R1";
    return "R2";
  endfunction

  task automatic cyc(string tag);
    logic [31:0] eb;
    int ix;
    #5;
    ix = f_idx(reg_sel, m_ir);
    eb = 0;
    if (en_reg) eb = (ix == 0) ? 32'd0 : m_rf[ix];
    if (en_imm) eb = f_imm(imm_sel, m_ir);
    if (en_alu) eb = f_alu(alu_op, m_a, m_b);
    if (en_mem) eb = mem_rdata;
    check((tag != "") ? tag : src_tag(), bus_o, eb);
    check("R3", mem_addr, m_ma);
    check("R3", {25'd0, opcode}, {25'd0, m_ir[6:0]});
    check("R11", {31'd0, a_eq_b}, {31'd0, m_a == m_b});
    @(posedge clk);
    if (!(en_mem && mem_busy)) begin
      if (ld_ir) m_ir = eb;
      if (ld_a) m_a = eb;
      if (ld_b) m_b = eb;
      if (ld_ma) m_ma = eb;
      if (reg_wr && ix != 0) m_rf[ix] = eb;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    {en_reg, en_imm, en_alu, en_mem, ld_ir, ld_a, ld_b, ld_ma, reg_wr, mem_busy} = '0;
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd1234));
    for (int i = 0; i < 33; i++) m_rf[i] = (i == 32) ? RPC : 32'd0;
    m_ir = 0; m_a = 0; m_b = 0; m_ma = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13: reset state through ports
    check("R13", mem_addr, 32'd0);
    check("R13", {31'd0, a_eq_b}, 32'd1);
    reg_sel = 3'd4; en_reg = 1; ld_ma = 1; cyc("R13");
    idle(); check("R13", mem_addr, RPC);
    // load instruction: rd=0, rs1=1, rs2=2, negative immediates
    mem_rdata = 32'hF820_8033; en_mem = 1; ld_ir = 1; cyc("R1");
    // R5: write x0 through rd field, read back zero
    idle(); en_imm = 1; imm_sel = 0; reg_sel = 0; reg_wr = 1; cyc("R7");
    idle(); en_reg = 1; reg_sel = 0; cyc("R5");
    // R6: link register and PC slot writes
    idle(); en_imm = 1; imm_sel = 1; reg_sel = 3; reg_wr = 1; cyc("R8");
    idle(); en_reg = 1; reg_sel = 3; cyc("R6");
    idle(); en_imm = 1; imm_sel = 2; reg_sel = 4; reg_wr = 1; cyc("R9");
    idle(); en_reg = 1; reg_sel = 4; cyc("R6");
    idle(); en_imm = 1; imm_sel = 3; cyc("R9");
    // R12: B=0, then busy load to A must not land
    idle(); en_reg = 1; reg_sel = 5; ld_b = 1; cyc("R5");
    idle(); en_mem = 1; mem_busy = 1; mem_rdata = 32'hDEAD_BEEF; ld_a = 1; ld_ma = 1; reg_wr = 1; reg_sel = 3; cyc("R12");
    idle(); en_alu = 1; alu_op = 0; cyc("R12");
    idle(); en_reg = 1; reg_sel = 3; cyc("R12");
    idle(); mem_busy = 1; cyc("R2");
    for (int i = 0; i < 3000; i++) begin
      idle();
      r = $urandom_range(0, 4);
      en_reg = (r == 1); en_imm = (r == 2); en_alu = (r == 3); en_mem = (r == 4);
      reg_sel = 3'($urandom_range(0, 7));
      imm_sel = 2'($urandom_range(0, 3));
      alu_op = 3'($urandom_range(0, 7));
      mem_rdata = $urandom;
      if ($urandom_range(0, 7) == 0) mem_rdata = m_a;
      mem_busy = ($urandom_range(0, 3) == 0);
      ld_ir = ($urandom_range(0, 3) == 0);
      ld_a = ($urandom_range(0, 2) == 0);
      ld_b = ($urandom_range(0, 2) == 0);
      ld_ma = ($urandom_range(0, 2) == 0);
      reg_wr = ($urandom_range(0, 2) == 0);
      mem_write = ($urandom_range(0, 3) == 0);
      #1;
      check("R1", mem_wdata, bus_o);
      check("R1", {30'd0, mem_we, mem_en}, {30'd0, mem_write, en_mem | mem_write});
      cyc("");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule